// File: doc/BRIEF.md
# Page-Mode External Memory Bus Sequencer

This block runs the external memory cycles of a core over a narrow multiplexed bus. A request carries a 16-bit address, a kind (instruction fetch, data read or data write) and a write byte. The block keeps the upper address byte of the most recent external cycle in a page register. When a new request falls in that same page, it runs one short access phase: the low address byte goes out on the address port and the matching strobe is asserted. When the page differs, it first runs a latch phase. In that phase the new upper byte goes out with ALE high so that an external latch can capture it, and the access phase follows.

Each phase lasts `HALF_CLKS` system clocks. Read and fetch data is captured from the data input on the last clock of the access phase. A single-cycle `done` pulse then follows. A `force_miss` input invalidates the page register, so the next access re-latches its page.

Top module: `pagebus_ctrl`

## Requirements
- R1: After reset, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `data_oe` and `done` are 0, `req_ready` is 1, and `addr_port` and `rdata` are 0.
- R2: The first request accepted after reset always takes the miss path, whatever its address.
- R3: A miss starts, in the cycle after acceptance, a latch phase of `HALF_CLKS` cycles. In it `ale` is 1, `addr_port` carries address bits 15:8, all three strobes are 1 and `data_oe` is 0.
- R4: The access phase lasts `HALF_CLKS` cycles, with `addr_port` carrying address bits 7:0. Kind 2'b00 (fetch) drives `psen_n` low. Kinds 2'b01 and 2'b11 (read) drive `rd_n` low. Kind 2'b10 (write) drives `wr_n` low. At most one strobe is low at a time.
- R5: A request whose bits 15:8 equal the stored page, while the page is valid, skips the latch phase: its access phase begins the cycle after acceptance and `ale` stays 0.
- R6: During a write's access phase `data_oe` is 1 and `data_out` carries the write byte. `data_oe` is 0 at every other time.
- R7: In the cycle after the access phase, `done` is 1 for exactly one cycle and `req_ready` is 1. For reads and fetches, `rdata` then shows `data_in` as sampled at the last access clock. Writes leave `rdata` unchanged. A new request may be accepted in the `done` cycle.
- R8: `force_miss` clears the page-valid flag, so the next request takes the miss path. If it arrives together with a request, that request still uses the old flag.
- R9: `req_valid` is ignored while `req_ready` is 0: no cycle starts and the stored page does not change.
- R10: On a miss, bits 15:8 become the stored page. An address in the previously stored page then misses again. While idle, `addr_port` shows the stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | 16 | Request address |
| req_kind | input | 2 | 00 fetch, 01/11 read, 10 write |
| req_wdata | input | 8 | Write byte |
| force_miss | input | 1 | Invalidate stored page |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Fetch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_port | output | 8 | Upper byte in latch phase, lower byte in access phase |
| data_out | output | 8 | Write data for the bus pad |
| data_oe | output | 1 | Data pad output enable |
| data_in | input | 8 | Data from the bus pad |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read or fetch byte |

## Verification
Take the clock edge that accepts a request as t. On a miss, the latch-phase outputs are due from t+1 to t+H, the access phase from t+H+1 to t+2H, and `done` with fresh `rdata` at t+2H+1. On a hit, everything arrives H cycles earlier. The bench enqueues one expected output record per future cycle at the moment it drives an accepted request, pops one record at every falling edge, and compares it with the live outputs. It drives a decoy value on `data_in` during the early access clocks, which shows whether the capture happens on the last one. Idle cycles are compared against the model's page and read byte.

// File: rtl/pagebus_ctrl.sv
module pagebus_ctrl #(
  parameter int DATA_W    = 8,
  parameter int HALF_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2*DATA_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              force_miss,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] addr_port,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);
  localparam logic [1:0] K_FETCH = 2'b00;
  localparam logic [1:0] K_WRITE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_XFER} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] wdata_q, page_q, rdata_q;
  logic              page_vld, done_q;

  wire accept = req_valid && (st == S_IDLE);
  wire hit    = page_vld && (req_addr[ADDR_W-1:DATA_W] == page_q);
  wire last   = (cnt == LAST);
  wire xfer   = (st == S_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      kind_q   <= K_FETCH;
      wdata_q  <= '0;
      page_q   <= '0;
      page_vld <= 1'b0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          addr_q  <= req_addr;
          kind_q  <= req_kind;
          wdata_q <= req_wdata;
          cnt     <= '0;
          if (hit) st <= S_XFER;
          else begin
            st     <= S_LATCH;
            page_q <= req_addr[ADDR_W-1:DATA_W];
          end
        end
        S_LATCH: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= S_XFER;
        end
        S_XFER: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            if (kind_q != K_WRITE) rdata_q <= data_in;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (accept && !hit) page_vld <= 1'b1;
      if (force_miss)     page_vld <= 1'b0;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign ale       = (st == S_LATCH);
  assign psen_n    = !(xfer && kind_q == K_FETCH);
  assign rd_n      = !(xfer && kind_q[0]);
  assign wr_n      = !(xfer && kind_q == K_WRITE);
  assign data_oe   = xfer && kind_q == K_WRITE;
  assign data_out  = wdata_q;
  assign addr_port = (st == S_LATCH) ? addr_q[ADDR_W-1:DATA_W] :
                     xfer            ? addr_q[DATA_W-1:0] : page_q;
  assign done      = done_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/pagebus_ctrl_chk.sv
module pagebus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic data_oe,
  input logic done
);
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

  p_latch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n && !data_oe));

  p_latch_to_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (!psen_n || !rd_n || !wr_n));

  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe == !wr_n);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind pagebus_ctrl pagebus_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .data_oe(data_oe), .done(done)
);

// File: tb/pagebus_ctrl_tb_top.sv
`timescale 1ns/1ps
module pagebus_ctrl_tb_top;
  localparam int H = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, force_miss = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_wdata = '0, data_in = '0;
  logic req_ready, ale, psen_n, rd_n, wr_n, data_oe, done;
  logic [7:0] addr_port, data_out, rdata;

  always #2.5 clk = ~clk;

  pagebus_ctrl #(.DATA_W(8), .HALF_CLKS(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_wdata(req_wdata),
    .force_miss(force_miss), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr_port(addr_port), .data_out(data_out),
    .data_oe(data_oe), .data_in(data_in), .done(done), .rdata(rdata)
  );

  typedef struct {
    logic ale, psen_n, rd_n, wr_n, oe, done, ready;
    logic [7:0] addr, dout, rdata, din;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [7:0] m_page = '0, m_rdata = '0;
  logic m_vld = 1'b0;
  string idle_tag = "R1";
  int checks = 0, failures = 0, nreq = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end

  function automatic exp_t idle_rec();
    exp_t e;
    e.ale = 0; e.psen_n = 1; e.rd_n = 1; e.wr_n = 1; e.oe = 0;
    e.done = 0; e.ready = 1; e.addr = m_page; e.dout = '0;
    e.rdata = m_rdata; e.din = 8'h00; e.tag = idle_tag;
    return e;
  endfunction

  task automatic push_req(input logic [15:0] a, input logic [1:0] k,
                          input logic [7:0] wd, input string tag);
    exp_t e;
    logic miss;
    logic [7:0] v;
    miss = !(m_vld && a[15:8] == m_page);
    v = 8'h3C ^ a[7:0] ^ 8'(nreq);
    nreq++;
    if (miss) begin
      m_page = a[15:8];
      m_vld = 1'b1;
      for (int i = 0; i < H; i++) begin
        e = idle_rec(); e.ale = 1; e.ready = 0; e.addr = a[15:8]; e.tag = tag;
        q.push_back(e);
      end
    end
    for (int i = 0; i < H; i++) begin
      e = idle_rec(); e.ready = 0; e.addr = a[7:0]; e.tag = tag;
      e.psen_n = (k != 2'b00); e.rd_n = !k[0]; e.wr_n = (k != 2'b10);
      e.oe = (k == 2'b10); e.dout = wd;
      e.din = (i == H - 1) ? v : ~v;
      q.push_back(e);
    end
    if (k != 2'b10) m_rdata = v;
    e = idle_rec(); e.done = 1; e.addr = m_page; e.rdata = m_rdata; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [1:0] k,
                      input logic [7:0] wd, input logic fm, input string tag);
    exp_t e;
    logic bad;
    @(negedge clk);
    e = (q.size() > 0) ? q.pop_front() : idle_rec();
    bad = (ale !== e.ale) || (psen_n !== e.psen_n) || (rd_n !== e.rd_n) ||
          (wr_n !== e.wr_n) || (data_oe !== e.oe) || (done !== e.done) ||
          (req_ready !== e.ready) || (addr_port !== e.addr) ||
          (rdata !== e.rdata) || (e.oe && data_out !== e.dout);
    checks++;
    if (bad) begin
      failures++;
      $display("FAIL %s t=%0t act ale=%b psen=%b rd=%b wr=%b oe=%b done=%b rdy=%b addr=%h dout=%h rdata=%h exp ale=%b psen=%b rd=%b wr=%b oe=%b done=%b rdy=%b addr=%h dout=%h rdata=%h",
        e.tag, $time, ale, psen_n, rd_n, wr_n, data_oe, done, req_ready, addr_port, data_out, rdata,
        e.ale, e.psen_n, e.rd_n, e.wr_n, e.oe, e.done, e.ready, e.addr, e.dout, e.rdata);
    end
    req_valid = v; req_addr = a; req_kind = k; req_wdata = wd; force_miss = fm;
    if (v && q.size() == 0) push_req(a, k, wd, tag);
    if (fm) m_vld = 1'b0;
    data_in = e.din;
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 16'h0, 2'b00, 8'h00, 0, idle_tag);
    step(0, 16'h0, 2'b00, 8'h00, 0, idle_tag);
  endtask

  task automatic run_req(input logic [15:0] a, input logic [1:0] k,
                         input logic [7:0] wd, input string tag);
    idle_tag = tag;
    step(1, a, k, wd, 0, tag);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_tag = "R1";
    repeat (3) step(0, 16'h0, 2'b00, 8'h00, 0, "R1");

    run_req(16'h1234, 2'b00, 8'h00, "R2");
    run_req(16'h1256, 2'b01, 8'h00, "R5");
    run_req(16'h12AA, 2'b10, 8'hC5, "R6");
    run_req(16'h12FF, 2'b00, 8'h00, "R4");
    run_req(16'h12F0, 2'b11, 8'h00, "R4");

    run_req(16'h3401, 2'b01, 8'h00, "R10");
    run_req(16'h1200, 2'b01, 8'h00, "R10");
    run_req(16'h1211, 2'b10, 8'h77, "R10");

    idle_tag = "R8";
    step(0, 16'h0, 2'b00, 8'h00, 1, "R8");
    step(0, 16'h0, 2'b00, 8'h00, 0, "R8");
    run_req(16'h1222, 2'b01, 8'h00, "R8");
    idle_tag = "R8";
    step(1, 16'h1233, 2'b00, 8'h00, 1, "R8");
    drain();
    run_req(16'h1244, 2'b01, 8'h00, "R8");

    idle_tag = "R9";
    step(1, 16'h5500, 2'b01, 8'h00, 0, "R9");
    while (q.size() > 1) step(1, 16'h6600, 2'b10, 8'hEE, 0, "R9");
    drain();
    run_req(16'h5501, 2'b00, 8'h00, "R9");

    idle_tag = "R7";
    step(1, 16'h7000, 2'b01, 8'h00, 0, "R7");
    while (q.size() > 1) step(0, 16'h0, 2'b00, 8'h00, 0, "R7");
    step(1, 16'h7001, 2'b00, 8'h00, 0, "R7");
    while (q.size() > 1) step(0, 16'h0, 2'b00, 8'h00, 0, "R7");
    step(1, 16'h8002, 2'b10, 8'h5A, 0, "R7");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule